// File: doc/BRIEF.md
# Master-Slave Gated Timer Pair

Two up-counting timers run from one internal clock through a shared prescaler, so both advance on the same ticks. The master timer compares its count against a compare register to produce a reference waveform. That waveform goes high on a match and low on rollover, and a master-mode field chooses what the master places on its trigger output. The slave timer picks its trigger through a trigger-select field. In gated mode it advances only while that trigger is high. Each change of the gate sets a sticky trigger flag, and software clears the flag by writing 0 to it.

Software drives the pair through a single-cycle write port: enable bits, counter-reset (update-generation) strobes, direct counter loads, compare and reload values, the prescaler ratio, and mode fields. A typical sequence sets the master to route its compare reference and the slave to gated mode. Software resets both counters, preloads the slave with a start value such as 0xE7, and enables the slave first and then the master. The slave then counts only during the master's reference-high windows. Clearing the master's enable stops the slave.

Top module: `gated_timer_pair`

## Requirements
- R1: After reset both counters read 0, the trigger output is 0, the flag is 0, both reload values are 0xFFFF and the prescaler ratio is 0.
- R2: A prescaler counter produces a tick once every ratio+1 clocks; the ratio is written at address 5. On each tick with the enable set (address 0, bit 0), the master counter goes up by one, and it goes from its reload value (address 4) to 0.
- R3: Writing a word with bit 0 set to address 1 (master) or 10 (slave) zeroes that counter on the next edge. Writing address 2 (master) or 11 (slave) loads the written value. Both take priority over counting in the same cycle.
- R4: The compare reference rises on the edge after the master count equals the compare value (address 3). It falls on the edge of a rollover tick, with rollover winning over a match. It is held low while the master is disabled.
- R5: Master-mode field bits [6:4] of address 0 select the trigger output: 100 gives the compare reference, 001 gives the master enable, and any other value gives 0.
- R6: The trigger-select field, bits [6:4] of address 9, connects the master trigger output to the slave when it is 000; any other value holds the slave trigger low.
- R7: Slave-mode field bits [2:0] of address 9 equal to 101 select gated mode. The slave trigger is registered once, and the slave, when enabled (address 8, bit 0), counts on a tick only while that registered gate is high. It goes from its reload value (address 12) to 0.
- R8: With any other slave-mode value, the enabled slave counts on every tick whatever its trigger.
- R9: In gated mode, a change of the registered gate in either direction sets the flag on the next edge. Writing a word with bit 0 clear to address 13 clears the flag, writing bit 0 set has no effect, and a set wins over a clear in the same cycle.
- R10: With the master in mode 100 and the slave gated, clearing the master enable stops the slave within two cycles and keeps it stopped.
- R11: A value loaded directly into the slave counter, such as 0xE7, appears on the next edge, and gated counting continues upward from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| mst_cnt | output | 16 | Master counter value |
| slv_cnt | output | 16 | Slave counter value |
| mst_trgo | output | 1 | Master trigger output |
| slv_flag | output | 1 | Slave trigger flag |

## Verification
Each internal state shows at a port within one or two edges. A prescaler phase error shifts the next change of the master count. A wrong compare-reference bit shows on the trigger output in mode 100 on the next edge, and on the slave count one tick later. A slip in gate timing appears as a slave count that is off by one at the window edges and as a flag that rises a cycle early or late. The bench follows every edge with a cycle model, so the first divergent cycle is reported.

// File: rtl/gtp_pkg.sv
package gtp_pkg;

  localparam int MODE_W = 3;
  typedef logic [MODE_W-1:0] mode_t;

  localparam logic [3:0] A_MST_CTRL = 4'd0;
  localparam logic [3:0] A_MST_UPD  = 4'd1;
  localparam logic [3:0] A_MST_CNT  = 4'd2;
  localparam logic [3:0] A_MST_CMP  = 4'd3;
  localparam logic [3:0] A_MST_ARR  = 4'd4;
  localparam logic [3:0] A_PSC      = 4'd5;
  localparam logic [3:0] A_SLV_CTRL = 4'd8;
  localparam logic [3:0] A_SLV_MODE = 4'd9;
  localparam logic [3:0] A_SLV_UPD  = 4'd10;
  localparam logic [3:0] A_SLV_CNT  = 4'd11;
  localparam logic [3:0] A_SLV_ARR  = 4'd12;
  localparam logic [3:0] A_SLV_FLAG = 4'd13;

  localparam mode_t MM_ENABLE = 3'b001;
  localparam mode_t MM_OC1REF = 3'b100;
  localparam mode_t SM_GATED  = 3'b101;
  localparam mode_t TS_MASTER = 3'b000;

  function automatic logic master_trigger(input mode_t mm, input logic en, input logic oc_ref);
    case (mm)
      MM_OC1REF: master_trigger = oc_ref;
      MM_ENABLE: master_trigger = en;
      default:   master_trigger = 1'b0;
    endcase
  endfunction

  function automatic logic slave_trigger(input mode_t ts, input logic trgo);
    slave_trigger = (ts == TS_MASTER) ? trgo : 1'b0;
  endfunction

  function automatic logic is_gated(input mode_t sm);
    is_gated = (sm == SM_GATED);
  endfunction

endpackage

// File: rtl/gtp_prescaler.sv
module gtp_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ratio,
  output logic         tick
);
  logic [W-1:0] div_q;

  assign tick = (div_q >= ratio);

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else if (tick) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/gtp_counter.sv
module gtp_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  function automatic logic [W-1:0] advance(input logic [W-1:0] c, input logic [W-1:0] top);
    advance = (c == top) ? '0 : c + 1'b1;
  endfunction

  assign wrap = step && (cnt == reload);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (clr) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) cnt <= advance(cnt, reload);
  end
endmodule

// File: rtl/gtp_oc_ref.sv
module gtp_oc_ref #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         wrap,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  output logic         oc_ref,
  output logic         match
);
  assign match = (cnt == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) oc_ref <= 1'b0;
    else if (!enable) oc_ref <= 1'b0;
    else if (wrap) oc_ref <= 1'b0;
    else if (match) oc_ref <= 1'b1;
  end
endmodule

// File: rtl/gtp_gate.sv
module gtp_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic gated,
  input  logic flag_clr,
  output logic gate_q,
  output logic gate_edge,
  output logic flag
);
  logic gate_d;

  assign gate_edge = gate_q ^ gate_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      gate_d <= 1'b0;
    end else begin
      gate_q <= trig_in;
      gate_d <= gate_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else if (gated && gate_edge) flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/gated_timer_pair.sv
module gated_timer_pair #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  mst_cnt,
  output logic [CNT_W-1:0]  slv_cnt,
  output logic              mst_trgo,
  output logic              slv_flag
);
  import gtp_pkg::*;

  localparam int FIELD_LO = 4;
  localparam logic [CNT_W-1:0] RELOAD_RST = {CNT_W{1'b1}};

  logic             mst_en, slv_en;
  mode_t            mst_mode, slv_mode, slv_tsel;
  logic [CNT_W-1:0] mst_cmp, mst_arr, slv_arr, psc;

  logic tick, mst_step, slv_step, mst_wrap, slv_wrap;
  logic mst_clr, mst_load, slv_clr, slv_load, flag_clr;
  logic oc1ref, oc_match, slv_trig, slv_gated, gate_q, gate_edge;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [3:0] target);
    hit = reg_we && (a == ADDR_W'(target));
  endfunction

  assign mst_clr  = hit(reg_addr, A_MST_UPD) && reg_wdata[0];
  assign slv_clr  = hit(reg_addr, A_SLV_UPD) && reg_wdata[0];
  assign mst_load = hit(reg_addr, A_MST_CNT);
  assign slv_load = hit(reg_addr, A_SLV_CNT);
  assign flag_clr = hit(reg_addr, A_SLV_FLAG) && !reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mst_en   <= 1'b0;
      slv_en   <= 1'b0;
      mst_mode <= '0;
      slv_mode <= '0;
      slv_tsel <= '0;
      mst_cmp  <= '0;
      mst_arr  <= RELOAD_RST;
      slv_arr  <= RELOAD_RST;
      psc      <= '0;
    end else begin
      if (hit(reg_addr, A_MST_CTRL)) begin
        mst_en   <= reg_wdata[0];
        mst_mode <= reg_wdata[FIELD_LO +: MODE_W];
      end
      if (hit(reg_addr, A_SLV_CTRL)) slv_en <= reg_wdata[0];
      if (hit(reg_addr, A_SLV_MODE)) begin
        slv_mode <= reg_wdata[0 +: MODE_W];
        slv_tsel <= reg_wdata[FIELD_LO +: MODE_W];
      end
      if (hit(reg_addr, A_MST_CMP)) mst_cmp <= reg_wdata;
      if (hit(reg_addr, A_MST_ARR)) mst_arr <= reg_wdata;
      if (hit(reg_addr, A_SLV_ARR)) slv_arr <= reg_wdata;
      if (hit(reg_addr, A_PSC))     psc     <= reg_wdata;
    end
  end

  gtp_prescaler #(.W(CNT_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .ratio(psc), .tick(tick)
  );

  assign mst_step = mst_en && tick;

  gtp_counter #(.W(CNT_W)) u_mst_cnt (
    .clk(clk), .rst_n(rst_n), .clr(mst_clr), .load(mst_load), .load_val(reg_wdata),
    .step(mst_step), .reload(mst_arr), .cnt(mst_cnt), .wrap(mst_wrap)
  );

  gtp_oc_ref #(.W(CNT_W)) u_oc (
    .clk(clk), .rst_n(rst_n), .enable(mst_en), .wrap(mst_wrap), .cnt(mst_cnt),
    .cmp(mst_cmp), .oc_ref(oc1ref), .match(oc_match)
  );

  assign mst_trgo  = master_trigger(mst_mode, mst_en, oc1ref);
  assign slv_trig  = slave_trigger(slv_tsel, mst_trgo);
  assign slv_gated = is_gated(slv_mode);

  gtp_gate u_gate (
    .clk(clk), .rst_n(rst_n), .trig_in(slv_trig), .gated(slv_gated),
    .flag_clr(flag_clr), .gate_q(gate_q), .gate_edge(gate_edge), .flag(slv_flag)
  );

  assign slv_step = slv_en && tick && (!slv_gated || gate_q);

  gtp_counter #(.W(CNT_W)) u_slv_cnt (
    .clk(clk), .rst_n(rst_n), .clr(slv_clr), .load(slv_load), .load_val(reg_wdata),
    .step(slv_step), .reload(slv_arr), .cnt(slv_cnt), .wrap(slv_wrap)
  );
endmodule

// File: rtl/gtp_checker.sv
module gtp_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mst_en,
  input logic             tick,
  input logic             mst_clr,
  input logic             mst_load,
  input logic [CNT_W-1:0] mst_cnt,
  input logic [CNT_W-1:0] mst_arr,
  input logic             oc1ref,
  input logic             slv_gated,
  input logic             gate_q,
  input logic             gate_edge,
  input logic             slv_clr,
  input logic             slv_load,
  input logic [CNT_W-1:0] slv_cnt,
  input logic             slv_flag
);
  assert_master_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mst_en && !mst_clr && !mst_load) |=> $stable(mst_cnt));

  assert_master_rollover_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_en && tick && mst_cnt == mst_arr && !mst_clr && !mst_load) |=> (mst_cnt == '0));

  assert_update_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mst_clr |=> (mst_cnt == '0));

  assert_ref_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_en |=> !oc1ref);

  assert_gate_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_gated && !gate_q && !slv_clr && !slv_load) |=> $stable(slv_cnt));

  assert_flag_on_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_gated && gate_edge) |=> slv_flag);
endmodule

bind gated_timer_pair gtp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mst_en(mst_en), .tick(tick), .mst_clr(mst_clr),
  .mst_load(mst_load), .mst_cnt(mst_cnt), .mst_arr(mst_arr), .oc1ref(oc1ref),
  .slv_gated(slv_gated), .gate_q(gate_q), .gate_edge(gate_edge), .slv_clr(slv_clr),
  .slv_load(slv_load), .slv_cnt(slv_cnt), .slv_flag(slv_flag)
);

// File: tb/gated_timer_pair_tb.sv
module gated_timer_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] mst_cnt, slv_cnt;
  logic        mst_trgo, slv_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gated_timer_pair u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mst_cnt(mst_cnt), .slv_cnt(slv_cnt), .mst_trgo(mst_trgo), .slv_flag(slv_flag)
  );

  // Cycle model built from the requirements
  logic [15:0] m_pc, m_psc, m_mcnt, m_cmp, m_marr, m_scnt, m_sarr;
  logic [2:0]  m_mmode, m_smode, m_ts;
  logic        m_men, m_sen, m_ref, m_gate, m_gate_d, m_flag;

  function automatic logic f_trgo(input logic [2:0] mm, input logic en, input logic r);
    if (mm == 3'b100) return r;
    if (mm == 3'b001) return en;
    return 1'b0;
  endfunction

  function automatic logic [15:0] f_next(input logic [15:0] c, input logic [15:0] top);
    return (c == top) ? 16'd0 : 16'(c + 16'd1);
  endfunction

  wire m_tick = (m_pc >= m_psc);
  wire m_wr   = reg_we;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc <= 0; m_psc <= 0; m_mcnt <= 0; m_cmp <= 0; m_marr <= 16'hFFFF;
      m_scnt <= 0; m_sarr <= 16'hFFFF; m_mmode <= 0; m_smode <= 0; m_ts <= 0;
      m_men <= 0; m_sen <= 0; m_ref <= 0; m_gate <= 0; m_gate_d <= 0; m_flag <= 0;
    end else begin
      m_pc <= m_tick ? 16'd0 : 16'(m_pc + 16'd1);
      if (m_wr && reg_addr == 0) begin m_men <= reg_wdata[0]; m_mmode <= reg_wdata[6:4]; end
      if (m_wr && reg_addr == 8) m_sen <= reg_wdata[0];
      if (m_wr && reg_addr == 9) begin m_smode <= reg_wdata[2:0]; m_ts <= reg_wdata[6:4]; end
      if (m_wr && reg_addr == 3) m_cmp <= reg_wdata;
      if (m_wr && reg_addr == 4) m_marr <= reg_wdata;
      if (m_wr && reg_addr == 12) m_sarr <= reg_wdata;
      if (m_wr && reg_addr == 5) m_psc <= reg_wdata;
      if (m_wr && reg_addr == 1 && reg_wdata[0]) m_mcnt <= 0;
      else if (m_wr && reg_addr == 2) m_mcnt <= reg_wdata;
      else if (m_men && m_tick) m_mcnt <= f_next(m_mcnt, m_marr);
      if (!m_men) m_ref <= 0;
      else if (m_tick && m_mcnt == m_marr) m_ref <= 0;
      else if (m_mcnt == m_cmp) m_ref <= 1;
      m_gate   <= (m_ts == 0) ? f_trgo(m_mmode, m_men, m_ref) : 1'b0;
      m_gate_d <= m_gate;
      if (m_wr && reg_addr == 10 && reg_wdata[0]) m_scnt <= 0;
      else if (m_wr && reg_addr == 11) m_scnt <= reg_wdata;
      else if (m_sen && m_tick && (m_smode != 3'b101 || m_gate)) m_scnt <= f_next(m_scnt, m_sarr);
      if (m_smode == 3'b101 && m_gate != m_gate_d) m_flag <= 1;
      else if (m_wr && reg_addr == 13 && !reg_wdata[0]) m_flag <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    chk(mst_cnt == m_mcnt, "R2 master count", mst_cnt, m_mcnt);
    chk(slv_cnt == m_scnt, "R7 slave count", slv_cnt, m_scnt);
    chk(mst_trgo == f_trgo(m_mmode, m_men, m_ref), "R5 trigger out", mst_trgo, f_trgo(m_mmode, m_men, m_ref));
    chk(slv_flag == m_flag, "R9 flag", slv_flag, m_flag);
  endtask

  task automatic tick1();
    @(negedge clk);
    compare();
    reg_we = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    compare();
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] snap;
    int unsigned seed;
    seed = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mst_cnt == 0, "R1 master count", mst_cnt, 0);
    chk(slv_cnt == 0, "R1 slave count", slv_cnt, 0);
    chk(mst_trgo == 0, "R1 trigger", mst_trgo, 0);
    chk(slv_flag == 0, "R1 flag", slv_flag, 0);

    wr(5, 0); wr(3, 3); wr(4, 9);
    wr(0, 16'h0040);
    wr(9, 16'h0005);
    wr(1, 1); wr(10, 1);
    wr(11, 16'h00E7);
    tick1();
    chk(slv_cnt == 16'h00E7, "R11 slave preload", slv_cnt, 16'h00E7);
    wr(8, 1);
    wr(0, 16'h0041);
    for (int i = 0; i < 50 && mst_cnt != 1; i++) tick1();
    chk(mst_trgo == 0, "R4 ref low after rollover", mst_trgo, 0);
    for (int i = 0; i < 50 && mst_cnt != 5; i++) tick1();
    chk(mst_trgo == 1, "R4 ref high after match", mst_trgo, 1);
    repeat (30) tick1();
    chk(slv_cnt > 16'h00E7, "R11 counting resumes", slv_cnt, 16'h00E8);
    wr(1, 1); tick1();
    chk(mst_cnt == 0, "R3 update clears master", mst_cnt, 0);
    wr(0, 16'h0040);
    repeat (3) tick1();
    snap = slv_cnt;
    repeat (10) tick1();
    chk(slv_cnt == snap, "R10 slave stopped", slv_cnt, snap);
    chk(mst_trgo == 0, "R10 trigger low", mst_trgo, 0);

    wr(9, 16'h0015);
    wr(0, 16'h0041);
    repeat (3) tick1();
    snap = slv_cnt;
    repeat (30) tick1();
    chk(slv_cnt == snap, "R6 unselected trigger", slv_cnt, snap);

    wr(9, 16'h0000);
    wr(11, 0);
    repeat (11) tick1();
    chk(slv_cnt == 10, "R8 free-running slave", slv_cnt, 10);

    wr(0, 16'h0011); tick1();
    chk(mst_trgo == 1, "R5 enable as trigger", mst_trgo, 1);
    wr(0, 16'h0021); tick1();
    chk(mst_trgo == 0, "R5 reserved mode", mst_trgo, 0);
    wr(13, 0); tick1();
    chk(slv_flag == 0, "R9 flag cleared", slv_flag, 0);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 100 < 25) begin
        int unsigned pick;
        pick = $urandom % 12;
        case (pick)
          0: wr(0, 16'({($urandom % 4 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'b100 : 3'b001), 3'b000, 1'($urandom % 4 != 0)}));
          1: wr(1, 16'($urandom % 2));
          2: wr(2, 16'($urandom % 48));
          3: wr(3, 16'($urandom % 44));
          4: wr(4, 16'(4 + $urandom % 40));
          5: wr(5, 16'($urandom % 3));
          6: wr(8, 16'($urandom % 4 != 0));
          7: wr(9, 16'({(($urandom % 4 == 0) ? 3'($urandom) : 3'b000), 1'b0,
                        (($urandom % 4 == 0) ? 3'($urandom) : 3'b101)}));
          8: wr(10, 16'($urandom % 2));
          9: wr(11, 16'($urandom % 48));
          10: wr(12, 16'(4 + $urandom % 40));
          default: wr(13, 16'($urandom % 2));
        endcase
      end else begin
        tick1();
      end
    end
    tick1();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule